// File: doc/BRIEF.md
# Framed Serial Converter Data Port

This block is the digital serial port of a multichannel 12-bit data converter. Each read frame carries a 16-bit word out of the device: one zero bit, the three channel-address bits of the control register, and the twelve result bits. All bits go out MSB first. Each write frame carries a 5-bit control word into the device. The first three bits of that word select the channel. The last two bits are general control flags.

The port has two modes, chosen by one input. In master mode, the block drives the serial clock at half the system clock, drives the active-low receive sync, and starts a frame on each conversion-done strobe. In slave mode, the host supplies the serial clock and receive sync. All serial inputs are treated as synchronous to the system clock. The block finds serial-clock falling edges by comparing each sample with the one taken a cycle earlier. The two syncs may be tied together for full-duplex use. A build-time parameter selects how the result is encoded in the frame: straight binary, or two's complement (formed by inverting the result MSB).

Top module: `sport_conv`

## Requirements
- R1: In reset and right after it: sdo_o=0, chan_o=0, flags_o=0, sclk_o=1, rfs_n_o=1.
- R2: A read frame is {1'b0, chan[2:0], code[11:0]}, shifted MSB first. The first bit is on sdo_o once receive sync is low. Bit k (k=0..15, counted from the MSB) holds until the k-th serial-clock falling edge.
- R3: sdo_o is 0 whenever no read frame is active, including after the 16th falling edge.
- R4: After the 5th falling edge of a write frame (transmit sync low), the five sampled bits b0..b4 (first to last) update the control register at once: chan_o={b0,b1,b2} and flags_o={b3,b4}.
- R5: Input bits after the fifth bit of a write frame do not change chan_o or flags_o.
- R6: A write frame whose transmit sync rises before the 5th falling edge leaves chan_o and flags_o unchanged. The control outputs change only after a cycle in which tfs_n_i was low.
- R7: In master mode, when the port is idle, result_vld_i starts a frame. rfs_n_o then stays low for exactly 32 system-clock cycles, sclk_o toggles every cycle while it is low, and 16 falling edges occur. A result_vld_i pulse during a frame is ignored, and rfs_n_o falls only after a cycle in which result_vld_i was high.
- R8: Master-mode frames carry the same content and bit timing as R2, with sdo_o stable when sclk_o falls. The channel field is the value chan_o had when the frame started.
- R9: With TWOS_COMP=1, the 12-bit code field is the result with its MSB inverted. With TWOS_COMP=0, it is the result unchanged.
- R10: With both syncs low together, a read frame and a write frame run at the same time. The outgoing channel field is the value from before the write.
- R11: In slave mode (slave_mode_i=1), sclk_o and rfs_n_o stay at 1 and result_vld_i has no effect.
- R12: In slave mode, raising rfs_n_i before 16 falling edges ends the read frame, and sdo_o returns to 0 by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slave_mode_i | input | 1 | 1: host drives serial clock and receive sync; 0: block drives them |
| sclk_i | input | 1 | Serial clock from the host (slave mode) |
| rfs_n_i | input | 1 | Active-low receive sync from the host (slave mode) |
| tfs_n_i | input | 1 | Active-low transmit sync (both modes) |
| sdi_i | input | 1 | Serial control data in |
| result_i | input | 12 | Converter result, straight binary |
| result_vld_i | input | 1 | Conversion-done strobe (starts a master frame) |
| sdo_o | output | 1 | Serial frame data out |
| chan_o | output | 3 | Channel address from the control register |
| flags_o | output | 2 | Control flags from the control register |
| sclk_o | output | 1 | Generated serial clock (master mode) |
| rfs_n_o | output | 1 | Generated active-low receive sync (master mode) |

## Verification
A wrong shift count or a stale channel field shows up as a bit mismatch at a falling edge of the same frame. A read frame that never ends shows up as a nonzero sdo_o at most two cycles after the sync rises. A corrupted control register shows up at once on chan_o and flags_o. It also shows up in the next read frame as a wrong channel field. A fault in the master sequencer shows up within one frame, about 34 cycles, as a wrong count of sync-low cycles or of falling edges.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic {
    SPORT_MASTER = 1'b0,
    SPORT_SLAVE  = 1'b1
  } sport_mode_e;

  localparam int unsigned SPORT_LEAD_W = 1;
endpackage

// File: rtl/sport_mclk_gen.sv
module sport_mclk_gen #(
  parameter int unsigned BITS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_req_i,
  output logic sclk_o,
  output logic rfs_n_o,
  output logic start_o
);
  localparam int unsigned HALF_N = 2 * BITS;
  localparam int unsigned CNT_W  = $clog2(HALF_N);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_N - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sclk_q, rfs_q;

  assign start_o = en_i & rfs_q & start_req_i;
  assign sclk_o  = sclk_q;
  assign rfs_n_o = rfs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
      rfs_q  <= 1'b1;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
      rfs_q  <= 1'b1;
    end else if (start_o) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
      rfs_q  <= 1'b0;
    end else if (!rfs_q) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        sclk_q <= 1'b1;
        rfs_q  <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        sclk_q <= ~sclk_q;
      end
    end
  end
endmodule

// File: rtl/sport_tx.sv
module sport_tx #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] frame_i,
  input  logic         fall_i,
  input  logic         abort_i,
  output logic         sdo_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  assign sdo_o = act_q & sh_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= frame_i;
      cnt_q <= CNT_W'(W);
      act_q <= 1'b1;
    end else if (abort_i) begin
      act_q <= 1'b0;
    end else if (act_q && fall_i) begin
      sh_q  <= {sh_q[W-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sport_rx.sv
module sport_rx #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sync_fall_i,
  input  logic         sync_n_i,
  input  logic         fall_i,
  input  logic         sdi_i,
  output logic [W-1:0] ctrl_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [W-2:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;
  logic [W-1:0]     ctrl_q;

  assign ctrl_o = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      ctrl_q <= '0;
    end else if (sync_fall_i) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (sync_n_i) begin
      act_q <= 1'b0;
    end else if (act_q && fall_i && (cnt_q < CNT_W'(W))) begin
      cnt_q <= cnt_q + 1'b1;
      // commit all bits at once on the last one
      if (cnt_q == CNT_W'(W - 1)) ctrl_q <= {sh_q, sdi_i};
      else                        sh_q   <= {sh_q[W-3:0], sdi_i};
    end
  end
endmodule

// File: rtl/sport_conv.sv
module sport_conv
  import sport_pkg::*;
#(
  parameter int unsigned RES_W     = 12,
  parameter int unsigned CHAN_W    = 3,
  parameter int unsigned FLAG_W    = 2,
  parameter bit          TWOS_COMP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slave_mode_i,
  input  logic              sclk_i,
  input  logic              rfs_n_i,
  input  logic              tfs_n_i,
  input  logic              sdi_i,
  input  logic [RES_W-1:0]  result_i,
  input  logic              result_vld_i,
  output logic              sdo_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              sclk_o,
  output logic              rfs_n_o
);
  localparam int unsigned FRAME_W = SPORT_LEAD_W + CHAN_W + RES_W;
  localparam int unsigned CTRL_W  = CHAN_W + FLAG_W;

  sport_mode_e       mode;
  logic              is_slave;
  logic              sclk_m, m_start;
  logic              sclk_eff, sclk_d, rfs_d, tfs_d;
  logic              sclk_fall, rfs_fall, tfs_fall;
  logic              tx_load, tx_abort;
  logic [RES_W-1:0]  res_code;
  logic [FRAME_W-1:0] frame;
  logic [CTRL_W-1:0] ctrl;

  assign mode     = sport_mode_e'(slave_mode_i);
  assign is_slave = (mode == SPORT_SLAVE);

  assign sclk_eff = is_slave ? sclk_i : sclk_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b1;
      rfs_d  <= 1'b1;
      tfs_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_eff;
      rfs_d  <= rfs_n_i;
      tfs_d  <= tfs_n_i;
    end
  end

  assign sclk_fall = sclk_d & ~sclk_eff;
  assign rfs_fall  = is_slave & rfs_d & ~rfs_n_i;
  assign tfs_fall  = tfs_d & ~tfs_n_i;
  // master frames load on the start strobe so bit 0 settles before the first fall
  assign tx_load   = rfs_fall | m_start;
  assign tx_abort  = is_slave & rfs_n_i;

  generate
    if (TWOS_COMP) begin : g_twos
      assign res_code = {~result_i[RES_W-1], result_i[RES_W-2:0]};
    end else begin : g_bin
      assign res_code = result_i;
    end
  endgenerate

  assign frame   = {{SPORT_LEAD_W{1'b0}}, ctrl[CTRL_W-1 -: CHAN_W], res_code};
  assign chan_o  = ctrl[CTRL_W-1 -: CHAN_W];
  assign flags_o = ctrl[FLAG_W-1:0];

  sport_mclk_gen #(.BITS(FRAME_W)) u_mclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (~is_slave),
    .start_req_i(result_vld_i),
    .sclk_o     (sclk_m),
    .rfs_n_o    (rfs_n_o),
    .start_o    (m_start)
  );

  assign sclk_o = sclk_m;

  sport_tx #(.W(FRAME_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tx_load),
    .frame_i(frame),
    .fall_i (sclk_fall),
    .abort_i(tx_abort),
    .sdo_o  (sdo_o)
  );

  sport_rx #(.W(CTRL_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_fall_i(tfs_fall),
    .sync_n_i   (tfs_n_i),
    .fall_i     (sclk_fall),
    .sdi_i      (sdi_i),
    .ctrl_o     (ctrl)
  );
endmodule

// File: rtl/sport_conv_chk.sv
module sport_conv_chk #(
  parameter int unsigned RES_W  = 12,
  parameter int unsigned CHAN_W = 3,
  parameter int unsigned FLAG_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slave_mode_i,
  input logic              sclk_i,
  input logic              rfs_n_i,
  input logic              tfs_n_i,
  input logic              sdi_i,
  input logic [RES_W-1:0]  result_i,
  input logic              result_vld_i,
  input logic              sdo_o,
  input logic [CHAN_W-1:0] chan_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              sclk_o,
  input logic              rfs_n_o
);
  // R12
  rd_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_mode_i && rfs_n_i) |=> !sdo_o);

  // R11
  slave_idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_mode_i |=> (sclk_o && rfs_n_o));

  // R7
  mclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_mode_i && !rfs_n_o && $past(!rfs_n_o)) |-> (sclk_o != $past(sclk_o)));

  // R7
  mframe_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rfs_n_o) |-> $past(result_vld_i && !slave_mode_i));

  // R6
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({chan_o, flags_o}) |-> $past(!tfs_n_i));

  // R3
  m_idle_sdo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_mode_i && $past(!slave_mode_i) && rfs_n_o) |-> !sdo_o);
endmodule

bind sport_conv sport_conv_chk #(.RES_W(RES_W), .CHAN_W(CHAN_W), .FLAG_W(FLAG_W)) u_chk (.*);

// File: tb/sport_conv_bench.sv
module sport_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b1;
  logic        sclk = 1'b1;
  logic        rfs_n = 1'b1;
  logic        tfs_reg = 1'b1;
  logic        tie = 1'b0;
  logic        sdi = 1'b0;
  logic [11:0] res = '0;
  logic        rvld = 1'b0;
  logic        tfs_w;

  logic        sdo_a, sdo_b, sclk_oa, sclk_ob, rfs_oa, rfs_ob;
  logic [2:0]  chan_a, chan_b;
  logic [1:0]  flg_a, flg_b;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;
  logic [4:0]  ctrl_m = '0;

  always #10 clk = ~clk;

  assign tfs_w = tie ? rfs_oa : tfs_reg;

  sport_conv u_sport_conv (
    .clk_i(clk), .rst_ni(rst_n), .slave_mode_i(mode), .sclk_i(sclk),
    .rfs_n_i(rfs_n), .tfs_n_i(tfs_w), .sdi_i(sdi), .result_i(res),
    .result_vld_i(rvld), .sdo_o(sdo_a), .chan_o(chan_a), .flags_o(flg_a),
    .sclk_o(sclk_oa), .rfs_n_o(rfs_oa)
  );

  sport_conv #(.TWOS_COMP(1'b1)) u_sport_conv_tc (
    .clk_i(clk), .rst_ni(rst_n), .slave_mode_i(mode), .sclk_i(sclk),
    .rfs_n_i(rfs_n), .tfs_n_i(tfs_w), .sdi_i(sdi), .result_i(res),
    .result_vld_i(rvld), .sdo_o(sdo_b), .chan_o(chan_b), .flags_o(flg_b),
    .sclk_o(sclk_ob), .rfs_n_o(rfs_ob)
  );

  function automatic logic [15:0] exp_frame(input logic [2:0] ch, input logic [11:0] r, input bit tc);
    return {1'b0, ch, tc ? {~r[11], r[10:0]} : r};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_ctrl(input string req);
    chk({chan_a, flg_a} == ctrl_m, req, {chan_a, flg_a}, ctrl_m);
    chk({chan_b, flg_b} == ctrl_m, req, {chan_b, flg_b}, ctrl_m);
  endtask

  task automatic slave_frame(input logic [15:0] din, input int nfall, input bit rd, input bit wr);
    logic [15:0] e0, e1;
    string rq;
    e0 = exp_frame(ctrl_m[4:2], res, 1'b0);
    e1 = exp_frame(ctrl_m[4:2], res, 1'b1);
    @(negedge clk);
    rfs_n = !rd; tfs_reg = !wr; sdi = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < nfall; k++) begin
      sclk = 1'b1; sdi = din[15-k];
      repeat (3) @(negedge clk);
      if (rd) begin
        rq = (rd && wr) ? "R10" : "R2";
        chk(sdo_a == e0[15-k], rq, sdo_a, e0[15-k]);
        chk(sdo_b == e1[15-k], "R9", sdo_b, e1[15-k]);
      end
      sclk = 1'b0;
      repeat (3) @(negedge clk);
    end
    if (rd && nfall == 16) begin
      chk(sdo_a == 1'b0, "R3", sdo_a, 0);
      chk(sdo_b == 1'b0, "R3", sdo_b, 0);
    end
    rfs_n = 1'b1; tfs_reg = 1'b1;
    @(negedge clk);
    chk(sdo_a == 1'b0, (nfall < 16 && rd) ? "R12" : "R3", sdo_a, 0);
    sclk = 1'b1;
    @(negedge clk);
    if (wr && nfall >= 5) ctrl_m = din[15:11];
    if (!wr || nfall < 5) chk_ctrl("R6");
    else if (nfall > 5)   chk_ctrl("R5");
    else                  chk_ctrl("R4");
  endtask

  task automatic master_frame(input logic [15:0] din, input bit extra);
    logic [15:0] e0, e1;
    int low_n, fidx;
    logic prev;
    e0 = exp_frame(ctrl_m[4:2], res, 1'b0);
    e1 = exp_frame(ctrl_m[4:2], res, 1'b1);
    low_n = 0; fidx = 0;
    @(negedge clk);
    mode = 1'b0; tie = 1'b1; sdi = din[15];
    @(negedge clk);
    prev = sclk_oa;
    rvld = 1'b1;
    for (int i = 0; i < 45; i++) begin
      @(negedge clk);
      if (i == 0) rvld = 1'b0;
      if (i == 12 && extra) rvld = 1'b1;
      if (i == 13) rvld = 1'b0;
      if (!rfs_oa) low_n++;
      if (prev && !sclk_oa && !rfs_oa && fidx < 16) begin
        chk(sdo_a == e0[15-fidx], "R8", sdo_a, e0[15-fidx]);
        chk(sdo_b == e1[15-fidx], "R9", sdo_b, e1[15-fidx]);
        fidx++;
      end
      if (!prev && sclk_oa && !rfs_oa && fidx < 16) sdi = din[15-fidx];
      prev = sclk_oa;
    end
    chk(low_n == 32, "R7", low_n, 32);
    chk(fidx == 16, "R7", fidx, 16);
    chk(rfs_oa == 1'b1 && sclk_oa == 1'b1, "R7", {rfs_oa, sclk_oa}, 2'b11);
    chk(sdo_a == 1'b0, "R3", sdo_a, 0);
    ctrl_m = din[15:11];
    chk_ctrl("R8");
    tie = 1'b0; mode = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0011));
    repeat (3) @(negedge clk);
    // R1
    chk({sdo_a, chan_a, flg_a, sclk_oa, rfs_oa} == 8'b0_000_00_11, "R1",
        {sdo_a, chan_a, flg_a, sclk_oa, rfs_oa}, 8'b0_000_00_11);
    rst_n = 1'b1;
    @(negedge clk);
    chk({sdo_a, chan_a, flg_a, sclk_oa, rfs_oa} == 8'b0_000_00_11, "R1",
        {sdo_a, chan_a, flg_a, sclk_oa, rfs_oa}, 8'b0_000_00_11);

    // R11: strobe ignored in slave mode
    rvld = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(sclk_oa && rfs_oa && !sdo_a, "R11", {sclk_oa, rfs_oa, sdo_a}, 3'b110);
    end
    rvld = 1'b0;

    // R4 write exactly five bits
    slave_frame({5'b101_10, 11'h0}, 5, 1'b0, 1'b1);
    // R2 read with chan 5
    res = 12'hA5C;
    slave_frame('0, 16, 1'b1, 1'b0);
    // R6 truncated write
    slave_frame({5'b010_01, 11'h7FF}, 4, 1'b0, 1'b1);
    // R5 trailing bits ignored
    slave_frame({5'b011_11, 11'h555}, 12, 1'b0, 1'b1);
    // R10 tied syncs, boundary codes for R9
    res = 12'h800;
    slave_frame({5'b110_01, 11'h2AA}, 16, 1'b1, 1'b1);
    res = 12'hFFF;
    slave_frame({5'b001_10, 11'h000}, 16, 1'b1, 1'b1);
    res = 12'h000;
    slave_frame('0, 16, 1'b1, 1'b0);
    // R12 aborted read
    res = 12'h7FF;
    slave_frame('0, 7, 1'b1, 1'b0);

    // master frames R7 R8
    res = 12'h3C1;
    master_frame({5'b111_01, 11'h123}, 1'b0);
    res = 12'h9E4;
    master_frame({5'b100_10, 11'h456}, 1'b1);
    res = 12'h800;
    master_frame({5'b010_11, 11'h000}, 1'b0);

    for (int n = 0; n < 24; n++) begin
      bit rd, wr;
      res = 12'($urandom);
      rd = 1'($urandom);
      wr = 1'($urandom) | !rd;
      slave_frame(16'($urandom), 3 + int'($urandom % 14), rd, wr);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule